// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer

This block is a watchdog peripheral on a simple register bus: a write strobe, an address, write data and combinational read data. A programmable divider turns the clock into ticks. A chain of four timeout stages counts those ticks down. When the running stage runs out, it performs its own action and hands over to the next stage that is not switched off. The action can be nothing, an interrupt, a CPU reset pulse or a system reset pulse. After the last stage the chain wraps to the first. Software keeps the chain from running out by writing to the feed register. Any such write sends the sequence back to the start.

A key register guards all the other registers, so that a stray write cannot change or feed the watchdog. Software writes the key, makes its change, then writes any other value to lock the block again. The reset outputs are timed pulses. The interrupt output is either a level that is held until software clears it, or a single-cycle pulse.

Top module: `wdog_multistage`

## Requirements
- R1: A write to any offset other than the key register (0x1C) has no effect unless the key register was last written with 0x50D83AA1. Writing any other value to 0x1C locks the block. Bit 0 of a read of 0x1C is 1 while the block is unlocked.
- R2: The register offsets read back as follows. 0x00 returns the 18-bit configuration. 0x04 returns the 16-bit divider. 0x08, 0x0C, 0x10 and 0x14 return the 32-bit timeouts of stages 0 to 3. The feed register at 0x18 reads as zero.
- R3: With divider P and stage timeout T, the stage expires T·P cycles after the sequence starts. A value of 0 in either register counts as 1. The output for that stage's action rises T·P+2 clock edges after the edge that accepts the write which started the sequence.
- R4: An accepted write to 0x18, whatever its data, restarts the sequence at the lowest-numbered stage that is not off, reloads that stage's timeout and clears the divider. If the write lands on the same cycle as an expiry, that expiry performs no action.
- R5: Each stage has a 2-bit action field in configuration bits [2s+2:2s+1], encoded as 0 = off, 1 = interrupt, 2 = CPU reset, 3 = system reset. After an expiry the sequence moves to the next stage that is not off, wrapping from stage 3 back to stage 0.
- R6: A CPU reset action drives a high pulse on the CPU reset output lasting (L+1)·4 cycles, where L is configuration bits [11:9]. A system reset action does the same on the system reset output, with L taken from bits [14:12].
- R7: Configuration bit 0 is the run bit. While it is 0, no stage counts and no action occurs. A write that sets it from 0 to 1 restarts the sequence in the same way as a feed.
- R8: An interrupt action does something only when bit 15 is set. With bit 16 set, the interrupt output stays high until a write to 0x00 with bit 18 set. With bit 17 set, the output is a single-cycle pulse. Bit 18 is write-only.
- R9: After reset every register reads zero, the block is locked and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, either level or pulse |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A feed write and the expiry of a stage can fall on the same cycle, and the feed must win. The bench starts a stage with a known timeout and divider. It then places a feed write so that the write is acted on in exactly the cycle in which the stage would expire. The interrupt must then rise T·P+2 edges after the feed write, not two edges after it. A second overlap comes from the chained stages. Reset pulses and interrupt events from neighbouring stages overlap in time on separate outputs, and each output's first rise and high-cycle count is compared with bench-computed values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int NSTG = 4;

    typedef enum logic [1:0] {
        ACT_OFF = 2'd0,
        ACT_IRQ = 2'd1,
        ACT_CPU = 2'd2,
        ACT_SYS = 2'd3
    } act_e;

    // bit 0 run, [8:1] stage actions, [11:9] cpu len, [14:12] sys len,
    // 15 irq enable, 16 level mode, 17 pulse mode
    typedef struct packed {
        logic                  edge_en;
        logic                  level_en;
        logic                  irq_en;
        logic [2:0]            sys_len;
        logic [2:0]            cpu_len;
        logic [NSTG-1:0][1:0]  act;
        logic                  run;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 32,
    parameter logic [DATA_W-1:0] KEY = 32'h50D8_3AA1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wen,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output cfg_t                       cfg,
    output logic [PRE_W-1:0]           pre,
    output logic [NSTG-1:0][CNT_W-1:0] tmo,
    output logic                       restart,
    output logic                       irq_clr
);
    localparam int IW       = ADDR_W - 2;
    localparam int IDX_CFG  = 0;
    localparam int IDX_PRE  = 1;
    localparam int IDX_TMO  = 2;
    localparam int IDX_FEED = IDX_TMO + NSTG;
    localparam int IDX_PROT = IDX_FEED + 1;

    typedef struct packed {
        cfg_t                       cfg;
        logic [PRE_W-1:0]           pre;
        logic [NSTG-1:0][CNT_W-1:0] tmo;
        logic                       unlocked;
        logic                       restart;
        logic                       clr;
    } regs_t;

    regs_t s_d, s_q;
    logic [IW-1:0] idx;

    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        s_d         = s_q;
        s_d.restart = 1'b0;
        s_d.clr     = 1'b0;
        if (wen) begin
            if (idx == IW'(IDX_PROT)) begin
                s_d.unlocked = (wdata == KEY);
            end else if (s_q.unlocked) begin
                if (idx == IW'(IDX_CFG)) begin
                    s_d.cfg     = cfg_t'(wdata[CFG_W-1:0]);
                    s_d.clr     = wdata[CFG_W];
                    s_d.restart = wdata[0] & ~s_q.cfg.run;
                end
                if (idx == IW'(IDX_PRE))  s_d.pre     = wdata[PRE_W-1:0];
                if (idx == IW'(IDX_FEED)) s_d.restart = 1'b1;
                for (int k = 0; k < NSTG; k++) begin
                    if (idx == IW'(IDX_TMO + k)) s_d.tmo[k] = wdata[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IW'(IDX_CFG))  rdata[CFG_W-1:0] = s_q.cfg;
        if (idx == IW'(IDX_PRE))  rdata[PRE_W-1:0] = s_q.pre;
        if (idx == IW'(IDX_PROT)) rdata[0]         = s_q.unlocked;
        for (int k = 0; k < NSTG; k++) begin
            if (idx == IW'(IDX_TMO + k)) rdata[CNT_W-1:0] = s_q.tmo[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg     = s_q.cfg;
    assign pre     = s_q.pre;
    assign tmo     = s_q.tmo;
    assign restart = s_q.restart;
    assign irq_clr = s_q.clr;

    // R1: a write while locked leaves every register and control pulse untouched
    assert_locked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && !s_q.unlocked && idx != IW'(IDX_PROT)) |=>
            ($stable(s_q.cfg) && $stable(s_q.pre) && $stable(s_q.tmo) && !s_q.restart && !s_q.clr));
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [NSTG-1:0][1:0]       act,
    input  logic [PRE_W-1:0]           pre,
    input  logic [NSTG-1:0][CNT_W-1:0] tmo,
    input  logic                       restart,
    output logic                       fire,
    output logic [1:0]                 fire_act
);
    localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

    typedef struct packed {
        logic [SW-1:0]    stage;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] div;
        logic             fire;
        logic [1:0]       fire_act;
    } seq_t;

    seq_t s_d, s_q;
    logic [PRE_W-1:0] lim;
    logic [SW-1:0]    nxt;

    // lowest stage at or after 'start' (wrapping) whose action is not off
    function automatic logic [SW-1:0] first_from(input int start,
                                                 input logic [NSTG-1:0][1:0] a);
        logic [SW-1:0] r;
        int            j;
        r = SW'(start % NSTG);
        for (int k = NSTG - 1; k >= 0; k--) begin
            j = (start + k) % NSTG;
            if (a[j] != 2'd0) r = SW'(j);
        end
        return r;
    endfunction

    always_comb begin
        lim        = (pre == '0) ? '0 : pre - 1'b1;
        s_d        = s_q;
        s_d.fire   = 1'b0;
        nxt        = first_from(int'(s_q.stage) + 1, act);
        if (restart) begin
            s_d.stage = first_from(0, act);
            s_d.cnt   = tmo[first_from(0, act)];
            s_d.div   = '0;
        end else if (run) begin
            if (s_q.div >= lim) begin
                s_d.div = '0;
                if (s_q.cnt <= CNT_W'(1)) begin
                    s_d.fire     = 1'b1;
                    s_d.fire_act = act[s_q.stage];
                    s_d.stage    = nxt;
                    s_d.cnt      = tmo[nxt];
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fire     = s_q.fire;
    assign fire_act = s_q.fire_act;

    // R7: with the run bit clear the chain is frozen and nothing expires
    assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(s_q.cnt) && $stable(s_q.stage) && !s_q.fire));

    // R4: a restart suppresses an expiry that would happen in the same cycle
    assert_feed_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !s_q.fire);
endmodule

// File: rtl/wdog_out.sv
module wdog_out
    import wdog_pkg::*;
#(
    parameter int PULSE_UNIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [1:0] fire_act,
    input  cfg_t       cfg,
    input  logic       irq_clr,
    output logic       irq_o,
    output logic       cpu_rst_o,
    output logic       sys_rst_o
);
    localparam int MAXP = 8 * PULSE_UNIT;
    localparam int PW   = $clog2(MAXP + 1);

    typedef struct packed {
        logic          pend;
        logic          edge_p;
        logic [PW-1:0] cpu_cnt;
        logic [PW-1:0] sys_cnt;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.edge_p = 1'b0;
        if (irq_clr)              s_d.pend    = 1'b0;
        if (s_q.cpu_cnt != '0)    s_d.cpu_cnt = s_q.cpu_cnt - 1'b1;
        if (s_q.sys_cnt != '0)    s_d.sys_cnt = s_q.sys_cnt - 1'b1;
        if (fire) begin
            unique case (act_e'(fire_act))
                ACT_IRQ: if (cfg.irq_en) begin
                    s_d.pend   = 1'b1;
                    s_d.edge_p = 1'b1;
                end
                ACT_CPU: s_d.cpu_cnt = PW'((int'(cfg.cpu_len) + 1) * PULSE_UNIT);
                ACT_SYS: s_d.sys_cnt = PW'((int'(cfg.sys_len) + 1) * PULSE_UNIT);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o     = (cfg.level_en & s_q.pend) | (cfg.edge_en & s_q.edge_p);
    assign cpu_rst_o = (s_q.cpu_cnt != '0);
    assign sys_rst_o = (s_q.sys_cnt != '0);

    // R6: a CPU reset pulse only starts from a CPU-reset expiry
    assert_cpu_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_o) |-> ($past(fire) && $past(fire_act) == 2'(ACT_CPU)));

    // R8: a clear with no new interrupt event drops the pending level
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fire) |=> !s_q.pend);
endmodule

// File: rtl/wdog_multistage.sv
module wdog_multistage
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int PRE_W      = 16,
    parameter int CNT_W      = 32,
    parameter int PULSE_UNIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              cpu_rst_o,
    output logic              sys_rst_o
);
    cfg_t                       cfg;
    logic [PRE_W-1:0]           pre;
    logic [NSTG-1:0][CNT_W-1:0] tmo;
    logic                       restart;
    logic                       irq_clr;
    logic                       fire;
    logic [1:0]                 fire_act;

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cfg(cfg), .pre(pre),
        .tmo(tmo), .restart(restart), .irq_clr(irq_clr)
    );

    wdog_seq #(
        .PRE_W(PRE_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(cfg.run), .act(cfg.act), .pre(pre),
        .tmo(tmo), .restart(restart), .fire(fire), .fire_act(fire_act)
    );

    wdog_out #(
        .PULSE_UNIT(PULSE_UNIT)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_act(fire_act),
        .cfg(cfg), .irq_clr(irq_clr), .irq_o(irq_o),
        .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
    );
endmodule

// File: tb/wdog_multistage_bench.sv
module wdog_multistage_bench;
    localparam logic [31:0] KEY = 32'h50D8_3AA1;
    localparam logic [4:0] A_CFG = 5'h00, A_PRE = 5'h04, A_TMO0 = 5'h08,
                           A_FEED = 5'h18, A_PROT = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o;

    int unsigned cyc = 0;
    int unsigned wcyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_multistage u_wdog_multistage (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfgw(int run, int a0, int a1, int a2, int a3,
                                         int cl, int sl, int ie, int lv, int ed, int clr);
        logic [31:0] v;
        v = 32'(run & 1) | 32'(a0 & 3) << 1 | 32'(a1 & 3) << 3 | 32'(a2 & 3) << 5 |
            32'(a3 & 3) << 7 | 32'(cl & 7) << 9 | 32'(sl & 7) << 12 |
            32'(ie & 1) << 15 | 32'(lv & 1) << 16 | 32'(ed & 1) << 17 | 32'(clr & 1) << 18;
        return v;
    endfunction

    function automatic int exp_delay(int t, int p);
        return ((t == 0) ? 1 : t) * ((p == 0) ? 1 : p) + 2;
    endfunction

    function automatic int pulse_w(int len);
        return (len + 1) * 4;
    endfunction

    // called at a negedge; the write is taken at the next posedge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0;
        wcyc = cyc;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int lim, output int dly);
        dly = -1;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (irq_o) begin
                dly = int'(cyc - wcyc);
                break;
            end
        end
    endtask

    task automatic quiesce();
        wr(A_CFG, cfgw(0,0,0,0,0,0,0,0,0,0,1));
        repeat (40) @(negedge clk);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] mdl [4];
        int dly, t, p;
        int irq_r1, irq_r2, irq_hi, cpu_r, cpu_hi, sys_r, sys_hi;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 irq", irq_o, 0);
        chk("R9 cpu", cpu_rst_o, 0);
        chk("R9 sys", sys_rst_o, 0);
        rd(A_CFG, d);  chk("R9 cfg", d, 0);
        rd(A_PROT, d); chk("R9 locked", d, 0);

        // R1: locked writes ignored, key unlocks, other value relocks
        wr(A_PRE, 32'd5);
        rd(A_PRE, d); chk("R1 locked write", d, 0);
        wr(A_PROT, KEY);
        rd(A_PROT, d); chk("R1 unlocked", d, 1);
        wr(A_PRE, 32'd5);
        rd(A_PRE, d); chk("R1 write taken", d, 5);
        wr(A_PROT, 32'd0);
        rd(A_PROT, d); chk("R1 relocked", d, 0);
        wr(A_PRE, 32'd9);
        rd(A_PRE, d); chk("R1 relocked write", d, 5);
        wr(A_PROT, KEY);

        // R2: random readback of stage timeouts, divider and feed
        for (int k = 0; k < 4; k++) mdl[k] = 0;
        for (int i = 0; i < 10; i++) begin
            int s;
            logic [31:0] v;
            s = int'($urandom % 4);
            v = $urandom;
            wr(A_TMO0 + 5'(4 * s), v);
            mdl[s] = v;
            for (int k = 0; k < 4; k++) begin
                rd(A_TMO0 + 5'(4 * k), d);
                chk("R2 timeout readback", d, mdl[k]);
            end
        end
        rd(A_FEED, d); chk("R2 feed reads zero", d, 0);
        wr(A_PRE, 32'h0001_ABCD);
        rd(A_PRE, d); chk("R2 divider width", d, 32'hABCD);
        for (int k = 0; k < 4; k++) wr(A_TMO0 + 5'(4 * k), 32'd0);

        // R3 / R8: random timeout and divider, level interrupt, then clear
        for (int i = 0; i < 6; i++) begin
            t = 2 + int'($urandom % 4);
            p = 2 + int'($urandom % 3);
            wr(A_TMO0, 32'(t));
            wr(A_PRE, 32'(p));
            wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,0));
            wait_irq(200, dly);
            chk("R3 expiry delay", dly, exp_delay(t, p));
            wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,1));
            chk("R8 level held before clear takes effect", irq_o, 1);
            @(negedge clk);
            chk("R8 clear drops level", irq_o, 0);
            quiesce();
        end

        // R3: zero divider and zero timeout both count as one
        wr(A_TMO0, 32'd0);
        wr(A_PRE, 32'd0);
        wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,0));
        wait_irq(50, dly);
        chk("R3 zero counts as one", dly, exp_delay(0, 0));
        quiesce();

        // R8: interrupt enable clear keeps output low
        wr(A_TMO0, 32'd2);
        wr(A_PRE, 32'd1);
        wr(A_CFG, cfgw(1,1,0,0,0,0,0,0,1,0,0));
        wait_irq(30, dly);
        chk("R8 irq disabled", dly, -1);
        quiesce();

        // R4: feed accepted on the expiry cycle cancels that expiry
        t = 3; p = 2;
        wr(A_TMO0, 32'(t));
        wr(A_PRE, 32'(p));
        wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,0));
        repeat (t * p - 1) @(negedge clk);
        wr(A_FEED, 32'hDEAD_0001);
        wait_irq(100, dly);
        chk("R4 feed on expiry cycle", dly, exp_delay(t, p));
        quiesce();

        // R4: feed restarts at first non-off stage (stage 0 off, stage 1 irq)
        wr(A_TMO0, 32'd40);
        wr(A_TMO0 + 5'd4, 32'd3);
        wr(A_PRE, 32'd1);
        wr(A_CFG, cfgw(1,0,1,0,0,0,0,1,1,0,0));
        repeat (2) @(negedge clk);
        wr(A_FEED, 32'd0);
        wait_irq(100, dly);
        chk("R4 restart at first active stage", dly, exp_delay(3, 1));
        quiesce();

        // R5 / R6 / R8: chain irq(pulse) -> cpu -> off -> sys -> wrap
        wr(A_TMO0, 32'd2);
        wr(A_TMO0 + 5'd4, 32'd2);
        wr(A_TMO0 + 5'd8, 32'd1);
        wr(A_TMO0 + 5'd12, 32'd10);
        wr(A_PRE, 32'd1);
        wr(A_CFG, cfgw(1,1,2,0,3,1,0,1,0,1,0));
        irq_r1 = -1; irq_r2 = -1; irq_hi = 0;
        cpu_r = -1; cpu_hi = 0; sys_r = -1; sys_hi = 0;
        for (int m = 1; m <= 19; m++) begin
            @(negedge clk);
            if (irq_o) begin
                irq_hi++;
                if (irq_r1 < 0) irq_r1 = m; else if (irq_r2 < 0) irq_r2 = m;
            end
            if (cpu_rst_o) begin cpu_hi++; if (cpu_r < 0) cpu_r = m; end
            if (sys_rst_o) begin sys_hi++; if (sys_r < 0) sys_r = m; end
        end
        chk("R5 stage0 irq", irq_r1, 4);
        chk("R8 pulse mode single cycles", irq_hi, 2);
        chk("R5 stage1 cpu reset", cpu_r, 6);
        chk("R6 cpu pulse width", cpu_hi, pulse_w(1));
        chk("R5 off stage skipped, sys reset", sys_r, 16);
        chk("R6 sys pulse width", sys_hi, pulse_w(0));
        chk("R5 wrap to stage0", irq_r2, 18);
        quiesce();

        // R7: clearing run freezes the chain; setting it restarts
        wr(A_TMO0, 32'd5);
        wr(A_PRE, 32'd2);
        wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,0));
        repeat (3) @(negedge clk);
        wr(A_CFG, cfgw(0,1,0,0,0,0,0,1,1,0,0));
        wait_irq(60, dly);
        chk("R7 stopped no action", dly, -1);
        wr(A_CFG, cfgw(1,1,0,0,0,0,0,1,1,0,0));
        wait_irq(100, dly);
        chk("R7 enable restarts", dly, exp_delay(5, 2));
        quiesce();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule